// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block sits on the host side of a single-lane SPI NOR flash. It accepts one request at a time and expands it into the complete series of flash commands that the request needs. A request is an operation code, a flash byte address and a byte length. Write data is pulled from the host one 32-bit word at a time, and read data is returned as 32-bit words. Each flash command is framed by chip-select. The bus runs in SPI mode 0: the clock idles low, the flash samples on the rising edge and the data changes on the falling edge. Bits go most significant first.

The sequencer handles the parts of a flash operation that software would otherwise have to string together. Before a page program it runs a write-enable handshake, and it keeps repeating that handshake until the flash reports that its write-enable latch is set. It selects the opcode set and the number of address bytes from the flash size parameter. It splits long reads into separate commands of bounded length. It does not wait for an erase or a program to finish inside the flash; the host issues read-status requests for that.

The control is one state machine. Its states are IDLE, OPCODE, ADDR, DUMMY, WRITE, READ, GAP and DONE. The transitions are:
- IDLE to OPCODE when a request is accepted.
- IDLE to DONE when the request has nothing to send.
- OPCODE to ADDR, READ or GAP, depending on the command.
- ADDR to DUMMY for a fast read, to WRITE for a program, and to GAP for an erase.
- DUMMY to READ.
- WRITE or READ to GAP after the last byte.
- GAP to OPCODE for the next command of the series.
- GAP to DONE after the last command.
- DONE to IDLE.

Each command runs under a frame kind. The kind is write-enable, poll (a status read inside the handshake) or main (the command the request asks for).

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, and whenever no request is running, cs_n is 1, sck is 0, and busy, done, rd_valid and wr_pop are 0. Whenever cs_n is 1, sck is 0.
- R2: Operation code 4 (read status) sends one frame: byte 0x05, then one byte is read. That byte is returned as a single rd_valid word, placed in bits 31:24 with the lower bits zero.
- R3: Operation code 5 (read ID) sends one frame: byte 0x9F, then 8 bytes are read. They are returned as two words, and the first byte received lands in bits 31:24 of the first word.
- R4: Operation code 3 (chip erase) sends exactly one frame, made of the single byte 0xC7.
- R5: Operation code 2 (sector erase) sends a frame of the single byte 0x06, then a frame of 0xD8 followed by the address, most significant byte first. There is no status read between them. With FLASH_ADDR_BITS at 24 or below the address is 3 bytes; above 24 it is 4 bytes and the opcode is 0xDC.
- R6: Operation code 1 (page program) first repeats a pair of frames: 0x06 alone, then 0x05 followed by one read byte. The pair repeats until the status byte read has bit 1 set. Only then is the program frame sent.
- R7: The program frame is 0x02, then the address, then exactly min(length, 64) data bytes. These bytes come from ceil(min(length, 64)/4) words, each taken with one wr_pop pulse. The bits of each word are sent in the order 31:24, 23:16, 15:8, 7:0.
- R8: Operation code 0 (read) sends a frame of 0x0B, then the address, then one dummy byte (8 clocks). After that the data bytes are clocked in.
- R9: A read longer than 128 bytes is split into frames of at most 128 data bytes each, and each frame's address moves forward by the previous frame's size. The data comes back packed 4 bytes per word, first byte in bits 31:24. The final partial word is left-justified and padded with zeros.
- R10: Between two frames of one request, cs_n stays high for at least 2 clock cycles.
- R11: busy rises in the cycle after a request is accepted and stays high until done. done is a one-cycle pulse, after which busy falls. A request presented while busy is ignored.
- R12: A read or program request with length 0, and any operation code of 6 or 7, sends no frame. Such a request still produces one done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 3 | Operation code (0 read, 1 program, 2 sector erase, 3 chip erase, 4 read status, 5 read ID) |
| req_addr | input | 32 | Flash byte address |
| req_len | input | LEN_W | Length in bytes for read and program |
| wr_word | input | 32 | Head word of the host write data |
| wr_pop | output | 1 | Consumes wr_word at this clock edge |
| rd_word | output | 32 | Packed read data word |
| rd_valid | output | 1 | rd_word is valid this cycle |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| cs_n | output | 1 | Flash chip-select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The bench runs a flash model that answers status polls with the write-enable bit clear for a chosen number of rounds. A design that checked the wrong status bit, or stopped polling too early, would send a different number of handshake pairs or issue the program frame too soon. Reads of 300 bytes, of 7 bytes and of random lengths cover the chunk boundary and the partial final word. An off-by-one in the chunk arithmetic would show up as a wrong address on the next frame or a misplaced pad. Program lengths above 64 and lengths not divisible by 4 catch a missing clip and a wrong count of words popped. Zero-length requests, an unused operation code and a request injected while busy catch a sequencer that sends stray frames or accepts commands on top of each other.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_PROG   = 3'd1,
        OP_SERASE = 3'd2,
        OP_CERASE = 3'd3,
        OP_RDSR   = 3'd4,
        OP_RDID   = 3'd5
    } req_op_e;

    typedef enum logic [1:0] {
        F_WREN = 2'd0,
        F_POLL = 2'd1,
        F_MAIN = 2'd2
    } frame_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_OPCODE = 3'd1,
        S_ADDR   = 3'd2,
        S_DUMMY  = 3'd3,
        S_WRITE  = 3'd4,
        S_READ   = 3'd5,
        S_GAP    = 3'd6,
        S_DONE   = 3'd7
    } state_e;

    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_RDSR   = 8'h05;
    localparam logic [7:0] OPC_RDID   = 8'h9F;
    localparam logic [7:0] OPC_CERASE = 8'hC7;

    function automatic logic [7:0] opcode_for(req_op_e op, frame_e fr, logic wide);
        logic [7:0] code;
        code = 8'h00;
        if (fr == F_WREN) begin
            code = OPC_WREN;
        end else if (fr == F_POLL) begin
            code = OPC_RDSR;
        end else begin
            case (op)
                OP_READ:   code = wide ? 8'h0C : 8'h0B;
                OP_PROG:   code = wide ? 8'h12 : 8'h02;
                OP_SERASE: code = wide ? 8'hDC : 8'hD8;
                OP_CERASE: code = OPC_CERASE;
                OP_RDSR:   code = OPC_RDSR;
                OP_RDID:   code = OPC_RDID;
                default:   code = 8'h00;
            endcase
        end
        return code;
    endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       active,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic [2:0]    bit_q;
    logic [7:0]    sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            bit_q     <= '0;
            sreg_q    <= '0;
            rx_byte   <= '0;
            sck       <= 1'b0;
            active    <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    sreg_q <= tx_byte;
                    cnt_q  <= '0;
                    bit_q  <= '0;
                    sck    <= 1'b0;
                end
            end else if (cnt_q == CW'(HALF - 1)) begin
                cnt_q <= '0;
                if (!sck) begin
                    sck     <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bit_q == 3'd7) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bit_q  <= bit_q + 3'd1;
                        sreg_q <= {sreg_q[6:0], 1'b0};
                    end
                end
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign mosi = sreg_q[7];

endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_vld,
    input  logic [7:0]  byte_in,
    input  logic        flush,
    output logic [31:0] word_out,
    output logic        word_vld
);
    logic [23:0] acc_q;
    logic [1:0]  n_q;
    logic [31:0] merged;

    assign merged = {acc_q, byte_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            n_q      <= '0;
            word_out <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (byte_vld) begin
                if (n_q == 2'd3 || flush) begin
                    word_out <= merged << (8 * (3 - int'(n_q)));
                    word_vld <= 1'b1;
                    acc_q    <= '0;
                    n_q      <= '0;
                end else begin
                    acc_q <= merged[23:0];
                    n_q   <= n_q + 2'd1;
                end
            end
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int FLASH_ADDR_BITS = 24,
    parameter int SCK_HALF        = 2,
    parameter int CS_GAP          = 2,
    parameter int RD_CHUNK        = 128,
    parameter int TX_MAX          = 64,
    parameter int LEN_W           = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [31:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [31:0]      wr_word,
    output logic             wr_pop,
    output logic [31:0]      rd_word,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic             cs_n,
    output logic             sck,
    output logic             mosi,
    input  logic             miso
);
    localparam int   ABYTES = (FLASH_ADDR_BITS > 24) ? 4 : 3;
    localparam logic WIDE   = (ABYTES == 4);
    localparam int   GW     = $clog2(CS_GAP + 1);

    state_e           state_q, state_d;
    frame_e           frame_q, frame_d;
    req_op_e          op_q;
    logic [31:0]      addr_q;
    logic [LEN_W-1:0] rem_q, idx_q, chunk_w;
    logic [GW-1:0]    gap_q;
    logic             wel_q;
    logic [31:0]      txw_q;

    logic             eng_start, eng_active, eng_done;
    logic [7:0]       eng_tx, eng_rx;
    logic             byte_state, last_byte, req_ok, req_wren;
    logic [1:0]       addr_sel;

    // Request qualification
    always_comb begin
        req_ok   = (req_op <= 3'd5) &&
                   !((req_op == OP_READ || req_op == OP_PROG) && req_len == '0);
        req_wren = (req_op == OP_PROG) || (req_op == OP_SERASE);
    end

    // Data bytes carried by the current frame
    always_comb begin
        chunk_w = '0;
        if (frame_q == F_POLL) begin
            chunk_w = LEN_W'(1);
        end else if (frame_q == F_MAIN) begin
            case (op_q)
                OP_READ: chunk_w = (rem_q > LEN_W'(RD_CHUNK)) ? LEN_W'(RD_CHUNK) : rem_q;
                OP_PROG: chunk_w = rem_q;
                OP_RDSR: chunk_w = LEN_W'(1);
                OP_RDID: chunk_w = LEN_W'(8);
                default: chunk_w = '0;
            endcase
        end
    end

    assign byte_state = (state_q == S_OPCODE) || (state_q == S_ADDR) || (state_q == S_DUMMY) ||
                        (state_q == S_WRITE)  || (state_q == S_READ);

    always_comb begin
        last_byte = 1'b1;
        if (state_q == S_ADDR)
            last_byte = (idx_q == LEN_W'(ABYTES - 1));
        else if (state_q == S_WRITE || state_q == S_READ)
            last_byte = (idx_q == chunk_w - LEN_W'(1));
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        frame_d = frame_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (!req_ok) begin
                        state_d = S_DONE;
                    end else begin
                        state_d = S_OPCODE;
                        frame_d = req_wren ? F_WREN : F_MAIN;
                    end
                end
            end
            S_OPCODE: begin
                if (eng_done) begin
                    if (frame_q == F_WREN)      state_d = S_GAP;
                    else if (frame_q == F_POLL) state_d = S_READ;
                    else begin
                        case (op_q)
                            OP_READ, OP_PROG, OP_SERASE: state_d = S_ADDR;
                            OP_RDSR, OP_RDID:            state_d = S_READ;
                            default:                     state_d = S_GAP;
                        endcase
                    end
                end
            end
            S_ADDR: begin
                if (eng_done && last_byte) begin
                    if (op_q == OP_READ)      state_d = S_DUMMY;
                    else if (op_q == OP_PROG) state_d = S_WRITE;
                    else                      state_d = S_GAP;
                end
            end
            S_DUMMY: if (eng_done) state_d = S_READ;
            S_WRITE, S_READ: if (eng_done && last_byte) state_d = S_GAP;
            S_GAP: begin
                if (gap_q == GW'(CS_GAP - 1)) begin
                    unique case (frame_q)
                        F_WREN: begin
                            state_d = S_OPCODE;
                            frame_d = (op_q == OP_PROG) ? F_POLL : F_MAIN;
                        end
                        F_POLL: begin
                            state_d = S_OPCODE;
                            frame_d = wel_q ? F_MAIN : F_WREN;
                        end
                        default: begin
                            state_d = (op_q == OP_READ && rem_q != '0) ? S_OPCODE : S_DONE;
                        end
                    endcase
                end
            end
            S_DONE: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            frame_q <= F_MAIN;
        end else begin
            state_q <= state_d;
            frame_q <= frame_d;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_READ;
            addr_q <= '0;
            rem_q  <= '0;
            idx_q  <= '0;
            gap_q  <= '0;
            wel_q  <= 1'b0;
            txw_q  <= '0;
        end else begin
            if (state_q == S_IDLE && req_valid && req_ok) begin
                op_q   <= req_op_e'(req_op);
                addr_q <= req_addr;
                rem_q  <= (req_op == OP_PROG && req_len > LEN_W'(TX_MAX)) ? LEN_W'(TX_MAX) : req_len;
            end
            if (state_d != state_q)
                idx_q <= '0;
            else if (eng_done)
                idx_q <= idx_q + LEN_W'(1);
            gap_q <= (state_q == S_GAP) ? gap_q + GW'(1) : '0;
            if (eng_done && state_q == S_READ && frame_q == F_POLL)
                wel_q <= eng_rx[1];
            if (wr_pop)
                txw_q <= wr_word;
            if (eng_done && last_byte && state_q == S_READ && frame_q == F_MAIN && op_q == OP_READ) begin
                addr_q <= addr_q + 32'(chunk_w);
                rem_q  <= rem_q - chunk_w;
            end
        end
    end

    // Byte selection toward the shift engine
    assign addr_sel = idx_q[1:0] + (WIDE ? 2'd0 : 2'd1);

    always_comb begin
        eng_tx = 8'h00;
        unique case (state_q)
            S_OPCODE: eng_tx = opcode_for(op_q, frame_q, WIDE);
            S_ADDR: begin
                unique case (addr_sel)
                    2'd0: eng_tx = addr_q[31:24];
                    2'd1: eng_tx = addr_q[23:16];
                    2'd2: eng_tx = addr_q[15:8];
                    2'd3: eng_tx = addr_q[7:0];
                endcase
            end
            S_WRITE: begin
                unique case (idx_q[1:0])
                    2'd0: eng_tx = wr_word[31:24];
                    2'd1: eng_tx = txw_q[23:16];
                    2'd2: eng_tx = txw_q[15:8];
                    2'd3: eng_tx = txw_q[7:0];
                endcase
            end
            default: eng_tx = 8'h00;
        endcase
    end

    // Outputs
    always_comb begin
        eng_start = byte_state && !eng_active && !eng_done;
        wr_pop    = eng_start && (state_q == S_WRITE) && (idx_q[1:0] == 2'd0);
        cs_n      = !byte_state;
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_DONE);
    end

    spi_byte_engine #(.HALF(SCK_HALF)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .tx_byte   (eng_tx),
        .miso      (miso),
        .sck       (sck),
        .mosi      (mosi),
        .active    (eng_active),
        .byte_done (eng_done),
        .rx_byte   (eng_rx)
    );

    rx_word_packer u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (eng_done && state_q == S_READ && frame_q == F_MAIN),
        .byte_in  (eng_rx),
        .flush    (last_byte),
        .word_out (rd_word),
        .word_vld (rd_valid)
    );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic busy,
    input logic done,
    input logic rd_valid,
    input logic wr_pop
);
    a_r1_sck_idle: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
    a_r10_cs_gap: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n);
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    a_r11_done_busy: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
    a_r11_busy_end: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(done));
    a_r11_frame_busy: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> busy);
    a_r7_pop_in_frame: assert property (@(posedge clk) disable iff (!rst_n) wr_pop |-> !cs_n);
    a_r9_rd_in_busy: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> busy);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .busy     (busy),
    .done     (done),
    .rd_valid (rd_valid),
    .wr_pop   (wr_pop)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [11:0] req_len = '0;
    logic [31:0] wr_word;
    logic        wr_pop, rd_valid, busy, done, cs_n, sck, mosi, miso;
    logic [31:0] rd_word;

    always #2.5 clk = ~clk;

    flash_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .wr_word(wr_word), .wr_pop(wr_pop),
        .rd_word(rd_word), .rd_valid(rd_valid), .busy(busy), .done(done),
        .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    // ---------------- flash model ----------------
    logic [7:0] log_b [0:15][0:139];
    int log_len [0:15];
    int nfr = 0, bitn = 0, wren_seen = 0, wel_need = 0;
    logic [7:0] sh = '0;
    logic miso_r = 1'b0;
    assign miso = miso_r;

    function automatic logic [7:0] rdb(logic [23:0] a);
        return a[7:0] ^ 8'h5A ^ a[15:8];
    endfunction

    function automatic logic [7:0] status_byte();
        return 8'hA0 | ((wren_seen >= wel_need) ? 8'h02 : 8'h00);
    endfunction

    function automatic logic [7:0] resp_byte(int k);
        int f;
        logic [23:0] a;
        f = (nfr > 0) ? nfr - 1 : 0;
        if (k == 0) return 8'h00;
        case (log_b[f][0])
            8'h05: return status_byte();
            8'h9F: return 8'(8'h20 + k);
            8'h0B: begin
                if (k < 5) return 8'h00;
                a = {log_b[f][1], log_b[f][2], log_b[f][3]} + 24'(k - 5);
                return rdb(a);
            end
            default: return 8'h00;
        endcase
    endfunction

    always @(negedge cs_n) begin
        if (nfr < 16) nfr = nfr + 1;
        log_len[nfr-1] = 0;
        bitn = 0;
        miso_r = 1'b0;
    end

    always @(posedge sck) if (!cs_n) begin
        sh = {sh[6:0], mosi};
        bitn = bitn + 1;
        if (bitn % 8 == 0 && nfr > 0) begin
            if (bitn / 8 - 1 < 140) log_b[nfr-1][bitn/8-1] = sh;
            log_len[nfr-1] = bitn / 8;
        end
    end

    always @(negedge sck) if (!cs_n) begin
        logic [7:0] rb;
        rb = resp_byte(bitn / 8);
        miso_r = rb[7 - (bitn % 8)];
    end

    always @(posedge cs_n)
        if (nfr > 0 && log_len[nfr-1] > 0 && log_b[nfr-1][0] == 8'h06)
            wren_seen = wren_seen + 1;

    // ---------------- host data source / sink ----------------
    int wk = 0;
    function automatic logic [7:0] sb(int s);
        return 8'(s * 13 + 3);
    endfunction
    assign wr_word = {sb(4*wk), sb(4*wk+1), sb(4*wk+2), sb(4*wk+3)};
    always @(posedge clk) if (wr_pop) wk <= wk + 1;

    logic [31:0] rdw [0:127];
    int nrd = 0;
    always @(negedge clk) if (rd_valid && nrd < 128) begin
        rdw[nrd] = rd_word;
        nrd = nrd + 1;
    end

    int hi_run = 0, min_gap = 1000;
    always @(negedge clk) begin
        if (cs_n) hi_run = hi_run + 1;
        else begin
            if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
            hi_run = 0;
        end
    end

    // ---------------- expected values ----------------
    logic [7:0] exp_b [0:15][0:139];
    int exp_len [0:15];
    int exp_n;
    logic [7:0] edat [0:511];
    int nd;
    int exp_pops;

    task automatic add_frame(input int len);
        exp_len[exp_n] = len;
        for (int i = 0; i < 140; i++) exp_b[exp_n][i] = 8'h00;
        exp_n = exp_n + 1;
    endtask

    task automatic build_expected(input logic [2:0] op, input logic [23:0] a, input int len, input int weln);
        int rem, c, n, pairs;
        logic [23:0] ca;
        exp_n = 0; nd = 0; exp_pops = 0;
        case (op)
            3'd0: begin
                rem = len; ca = a;
                while (rem > 0) begin
                    c = (rem > 128) ? 128 : rem;
                    add_frame(5 + c);
                    exp_b[exp_n-1][0] = 8'h0B;
                    exp_b[exp_n-1][1] = ca[23:16];
                    exp_b[exp_n-1][2] = ca[15:8];
                    exp_b[exp_n-1][3] = ca[7:0];
                    for (int j = 0; j < c; j++) begin
                        edat[nd] = rdb(ca + 24'(j));
                        nd = nd + 1;
                    end
                    ca = ca + 24'(c); rem = rem - c;
                end
            end
            3'd1: if (len > 0) begin
                n = (len > 64) ? 64 : len;
                pairs = (weln < 1) ? 1 : weln;
                for (int p = 0; p < pairs; p++) begin
                    add_frame(1); exp_b[exp_n-1][0] = 8'h06;
                    add_frame(2); exp_b[exp_n-1][0] = 8'h05;
                end
                add_frame(4 + n);
                exp_b[exp_n-1][0] = 8'h02;
                exp_b[exp_n-1][1] = a[23:16];
                exp_b[exp_n-1][2] = a[15:8];
                exp_b[exp_n-1][3] = a[7:0];
                for (int j = 0; j < n; j++) exp_b[exp_n-1][4+j] = sb(j);
                exp_pops = (n + 3) / 4;
            end
            3'd2: begin
                add_frame(1); exp_b[exp_n-1][0] = 8'h06;
                add_frame(4);
                exp_b[exp_n-1][0] = 8'hD8;
                exp_b[exp_n-1][1] = a[23:16];
                exp_b[exp_n-1][2] = a[15:8];
                exp_b[exp_n-1][3] = a[7:0];
            end
            3'd3: begin add_frame(1); exp_b[exp_n-1][0] = 8'hC7; end
            3'd4: begin
                add_frame(2); exp_b[exp_n-1][0] = 8'h05;
                edat[0] = 8'hA0 | ((weln <= 0) ? 8'h02 : 8'h00); nd = 1;
            end
            3'd5: begin
                add_frame(9); exp_b[exp_n-1][0] = 8'h9F;
                for (int j = 1; j <= 8; j++) begin edat[nd] = 8'(8'h20 + j); nd = nd + 1; end
            end
            default: ;
        endcase
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // ---------------- request driver ----------------
    int dn, busy_seen, busy_after, cyc;

    task automatic run_req(input logic [2:0] op, input logic [23:0] a, input int len,
                           input int weln, input bit poke);
        int got;
        @(negedge clk);
        nfr = 0; nrd = 0; wk = 0; wren_seen = 0; wel_need = weln; min_gap = 1000; dn = 0;
        req_valid = 1'b1; req_op = op; req_addr = {8'h00, a}; req_len = 12'(len);
        @(negedge clk);
        req_valid = 1'b0;
        busy_seen = busy;
        got = done;
        dn = dn + (done ? 1 : 0);
        cyc = 0;
        while (got == 0 && cyc < 40000) begin
            @(negedge clk);
            cyc = cyc + 1;
            if (poke && cyc == 20) begin
                req_valid = 1'b1; req_op = 3'd3;
            end else req_valid = 1'b0;
            if (done) begin got = 1; dn = dn + 1; end
        end
        req_valid = 1'b0;
        @(negedge clk); dn = dn + (done ? 1 : 0);
        busy_after = busy;
        @(negedge clk); dn = dn + (done ? 1 : 0);
    endtask

    task automatic verify(input logic [2:0] op, input logic [23:0] a, input int len,
                          input int weln, input string tag);
        int bad, bf, bi;
        longint av, ev;
        logic [31:0] ew;
        build_expected(op, a, len, weln);
        // frames on the wire
        bad = 0; av = 0; ev = 0;
        if (nfr != exp_n) begin bad = 1; av = nfr; ev = exp_n; end
        for (int f = 0; f < exp_n && !bad; f++) begin
            if (log_len[f] != exp_len[f]) begin bad = 1; av = log_len[f]; ev = exp_len[f]; end
            for (int i = 0; i < exp_len[f] && !bad; i++)
                if (log_b[f][i] !== exp_b[f][i]) begin
                    bad = 1; bf = f; bi = i; av = log_b[f][i]; ev = exp_b[f][i];
                end
        end
        chk(!bad, tag, "frame sequence", av, ev);
        // returned words
        bad = 0; av = nrd; ev = (nd + 3) / 4;
        if (nrd != (nd + 3) / 4) bad = 1;
        for (int w = 0; w < nrd && !bad; w++) begin
            ew = 32'h0;
            for (int k = 0; k < 4; k++)
                if (4*w + k < nd) ew[31-8*k -: 8] = edat[4*w + k];
            if (rdw[w] !== ew) begin bad = 1; av = rdw[w]; ev = ew; end
        end
        chk(!bad, tag, "read words", av, ev);
        chk(wk == exp_pops, tag, "words popped", wk, exp_pops);
        // R11: busy and done handshake
        chk(dn == 1 && busy_seen == 1 && busy_after == 0, "R11", "busy/done pulse",
            {dn, busy_seen, busy_after}, {1, 1, 0});
        // R10: chip-select gap between frames
        if (exp_n > 1) chk(min_gap >= 2, "R10", "cs_n high gap", min_gap, 2);
    endtask

    function automatic string tag_of(logic [2:0] op);
        case (op)
            3'd0: return "R8";
            3'd1: return "R6";
            3'd2: return "R5";
            3'd3: return "R4";
            3'd4: return "R2";
            3'd5: return "R3";
            default: return "R12";
        endcase
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails = fails + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int seed, op, ln, wn;
        logic [23:0] ad;
        seed = 32'h1F2E3D4C;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk(cs_n == 1 && sck == 0 && busy == 0 && done == 0 && rd_valid == 0 && wr_pop == 0,
            "R1", "idle outputs", {cs_n, sck, busy, done}, 4'b1000);

        run_req(3'd4, 24'h000000, 0, 0, 0);   verify(3'd4, 24'h0, 0, 0, "R2");
        run_req(3'd4, 24'h000000, 0, 99, 0);  verify(3'd4, 24'h0, 0, 99, "R2");
        run_req(3'd5, 24'h000000, 0, 0, 0);   verify(3'd5, 24'h0, 0, 0, "R3");
        run_req(3'd3, 24'h000000, 0, 0, 0);   verify(3'd3, 24'h0, 0, 0, "R4");
        run_req(3'd2, 24'h12_3456, 0, 0, 0);  verify(3'd2, 24'h123456, 0, 0, "R5");
        run_req(3'd1, 24'hAB_CD00, 5, 3, 0);  verify(3'd1, 24'hABCD00, 5, 3, "R6");
        run_req(3'd1, 24'h00_0100, 100, 1, 0); verify(3'd1, 24'h000100, 100, 1, "R7");
        run_req(3'd0, 24'h00_0FF0, 7, 0, 0);  verify(3'd0, 24'h000FF0, 7, 0, "R8");
        run_req(3'd0, 24'hFF_FF80, 300, 0, 0); verify(3'd0, 24'hFFFF80, 300, 0, "R9");
        run_req(3'd0, 24'h00_0000, 0, 0, 0);  verify(3'd0, 24'h0, 0, 0, "R12");
        run_req(3'd1, 24'h00_0000, 0, 1, 0);  verify(3'd1, 24'h0, 0, 1, "R12");
        run_req(3'd6, 24'h00_0000, 4, 0, 0);  verify(3'd6, 24'h0, 4, 0, "R12");
        // R11: request presented while busy must be ignored
        run_req(3'd4, 24'h000000, 0, 0, 1);   verify(3'd4, 24'h0, 0, 0, "R11");

        for (int it = 0; it < 20; it++) begin
            op = int'($urandom % 6);
            ad = 24'($urandom);
            ln = (op == 0) ? 1 + int'($urandom % 200) : 1 + int'($urandom % 80);
            wn = 1 + int'($urandom % 3);
            if (op == 4) wn = int'($urandom % 2);
            run_req(3'(op), ad, ln, wn, 0);
            verify(3'(op), ad, ln, wn, tag_of(3'(op)));
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule